// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block collects up to 64 level-sensitive interrupt request lines and picks the one a processor should service next. Each source has its own 3-bit priority level, set through a small register port. A level of zero switches the source off. The winner is the pending source with the highest level. When several pending sources share that level, the one with the highest source number wins. The winner's level and source number are driven combinationally to the processor, together with a valid flag.

A 4-bit current mask blocks every source whose level is less than or equal to it. When the mask-enable bit is set, an acknowledge raises the mask automatically. The old mask moves into a saved-mask register, and the current mask becomes the acknowledged level. This blocks that level and everything below it until software restores the saved value. The acknowledge returns the source number of the winner in the same cycle, or flags that nothing was pending.

Register map on the 7-bit address: 0x00 to 0x3F hold the per-source levels, where the address is the source number. 0x40 holds the current mask, 0x41 the saved mask and 0x42 the configuration. A write of any value to 0x43 copies the saved mask into the current mask. All other addresses read zero.

Top module: `intc_level_top`

## Requirements
- R1: Level register n (address n, 0 to 63) keeps the written value's bits 2..0 and reads bits 7..3 as zero. A write changes arbitration from the next cycle on.
- R2: After reset, every level register reads 0, the current mask (0x40) reads 0x00, the saved mask (0x41) reads 0x0F and the configuration (0x42) reads 0x00.
- R3: A source whose level is 0 never wins, whether or not its request line is high. With nothing eligible, `int_valid` is 0.
- R4: Among eligible sources, the winner has the highest level, and `int_level` reports it.
- R5: Among eligible sources that share the top level, the highest source number wins.
- R6: A source whose level is less than or equal to the current mask is not eligible. A mask of 7 or more blocks all sources.
- R7: An acknowledge drives `ack_src` with the current winner in that same cycle. If configuration bit 0 (mask enable) is 1, the next cycle shows the saved mask holding the previous current mask and the current mask holding the acknowledged level.
- R8: An acknowledge with no eligible source raises `ack_none` in that cycle and leaves both masks unchanged.
- R9: With mask enable at 0, an acknowledge still returns the winner but changes neither mask.
- R10: A write to address 0x43 copies the saved mask into the current mask on the next cycle.
- R11: The mask registers and the configuration read their stored bits (3..0 for the masks, bit 0 for the configuration) with all higher bits zero. Unmapped addresses read 0.
- R12: If an auto-masking acknowledge and a software write of the current mask fall in the same cycle, the acknowledge's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 64 | Request lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 7 | Read address |
| rd_data | output | 8 | Combinational read data |
| int_valid | output | 1 | An eligible source exists |
| int_level | output | 3 | Level of the winning source |
| int_src | output | 6 | Number of the winning source |
| ack | input | 1 | Acknowledge strobe |
| ack_src | output | 6 | Source taken by the acknowledge (0 when idle) |
| ack_none | output | 1 | Acknowledge found nothing pending |

## Verification
On every cycle, the assertions check the arbitration result. The winner must be eligible and above the mask, and no eligible source may beat it on level or, at equal level, on number. They also check that each acknowledge moves the masks as required and that level writes land in the addressed register. Some behaviours show up only in the bench's scenarios: the exact winner for chosen request patterns, the reset values seen through the read port, the zeroed reserved bits, and the sequence of an acknowledge followed by a restore.

// File: rtl/intc_prio_pkg.sv
package intc_prio_pkg;

    localparam int NUM_SRC = 64;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int LVL_W   = 3;
    localparam int MASK_W  = 4;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = SRC_W + 1;

    // offsets past the level-register window
    localparam int OFS_CUR     = 0;
    localparam int OFS_SAV     = 1;
    localparam int OFS_CFG     = 2;
    localparam int OFS_RESTORE = 3;

    localparam logic [MASK_W-1:0] SAV_RESET = '1;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
        logic [SRC_W-1:0] src;
    } cand_t;

    // hi covers higher source numbers: it wins ties
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        if (hi.valid && (!lo.valid || hi.lvl >= lo.lvl))
            return hi;
        return lo;
    endfunction

endpackage

// File: rtl/intc_level_regs.sv
module intc_level_regs
    import intc_prio_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int IDX_W = SRC_W,
    parameter int LV_W  = LVL_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [LV_W-1:0]            wr_lvl,
    output logic [N_SRC-1:0][LV_W-1:0] lvl_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                lvl_o[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                lvl_o[g] <= wr_lvl;
        end
    end

    AST_LVL_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> lvl_o[$past(wr_idx)] == $past(wr_lvl)); // R1

endmodule

// File: rtl/intc_mask_ctrl.sv
module intc_mask_ctrl
    import intc_prio_pkg::*;
#(
    parameter int MW   = MASK_W,
    parameter int LV_W = LVL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_cur_we,
    input  logic            sw_sav_we,
    input  logic            sw_cfg_we,
    input  logic            sw_restore,
    input  logic [MW-1:0]   sw_data,
    input  logic            ack_fire,
    input  logic [LV_W-1:0] ack_lvl,
    output logic [MW-1:0]   cur_mask,
    output logic [MW-1:0]   sav_mask,
    output logic            mask_en
);

    logic auto_raise;
    assign auto_raise = ack_fire && mask_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mask <= '0;
            sav_mask <= SAV_RESET;
            mask_en  <= 1'b0;
        end else begin
            if (auto_raise) begin
                sav_mask <= cur_mask;
                cur_mask <= MW'(ack_lvl);
            end else begin
                if (sw_cur_we)
                    cur_mask <= sw_data;
                else if (sw_restore)
                    cur_mask <= sav_mask;
                if (sw_sav_we)
                    sav_mask <= sw_data;
            end
            if (sw_cfg_we)
                mask_en <= sw_data[0];
        end
    end

    AST_ACK_SAVES_MASK: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && mask_en) |=> sav_mask == $past(cur_mask)); // R7
    AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && mask_en) |=> cur_mask == MW'($past(ack_lvl))); // R7
    AST_ACK_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !mask_en && !sw_cur_we && !sw_restore) |=> $stable(cur_mask)); // R9
    AST_RESTORE_COPIES: assert property (@(posedge clk) disable iff (rst)
        (sw_restore && !sw_cur_we && !(ack_fire && mask_en)) |=> cur_mask == $past(sav_mask)); // R10
    AST_ACK_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && mask_en && sw_cur_we) |=> cur_mask == MW'($past(ack_lvl))); // R12

endmodule

// File: rtl/intc_prio_tree.sv
module intc_prio_tree
    import intc_prio_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int IDX_W = SRC_W,
    parameter int LV_W  = LVL_W,
    parameter int MW    = MASK_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_SRC-1:0]           irq,
    input  logic [N_SRC-1:0][LV_W-1:0] lvl_i,
    input  logic [MW-1:0]              cur_mask,
    output cand_t                      win_o
);

    localparam int STAGES = IDX_W;

    logic [N_SRC-1:0] elig;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig[g] = irq[g] && (lvl_i[g] != '0) && (MW'(lvl_i[g]) > cur_mask);
    end

    for (genvar s = 0; s <= STAGES; s++) begin : g_st
        localparam int W = N_SRC >> s;
        cand_t nd [W];
        if (s == 0) begin : g_leaf
            for (genvar j = 0; j < W; j++) begin : g_j
                assign nd[j] = {elig[j], lvl_i[j], IDX_W'(j)};
            end
        end else begin : g_node
            for (genvar j = 0; j < W; j++) begin : g_j
                assign nd[j] = pick(g_st[s-1].nd[2*j], g_st[s-1].nd[2*j+1]);
            end
        end
    end

    assign win_o = g_st[STAGES].nd[0];

    // independent linear scan: is any eligible source strictly better?
    logic beaten;
    always_comb begin
        beaten = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && win_o.valid &&
                ((lvl_i[i] > win_o.lvl) ||
                 ((lvl_i[i] == win_o.lvl) && (IDX_W'(i) > win_o.src))))
                beaten = 1'b1;
        end
    end

    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        win_o.valid |-> (irq[win_o.src] && (MW'(win_o.lvl) > cur_mask))); // R6
    AST_IDLE_NOTHING_ELIG: assert property (@(posedge clk) disable iff (rst)
        !win_o.valid |-> (elig == '0)); // R3
    AST_WIN_UNBEATEN: assert property (@(posedge clk) disable iff (rst)
        win_o.valid |-> !beaten); // R5
    AST_WIN_LEVEL_MATCH: assert property (@(posedge clk) disable iff (rst)
        win_o.valid |-> (lvl_i[win_o.src] == win_o.lvl)); // R4

endmodule

// File: rtl/intc_level_top.sv
module intc_level_top
    import intc_prio_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int IDX_W = SRC_W,
    parameter int LV_W  = LVL_W,
    parameter int MW    = MASK_W,
    parameter int DW    = REG_W,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             int_valid,
    output logic [LV_W-1:0]  int_level,
    output logic [IDX_W-1:0] int_src,
    input  logic             ack,
    output logic [IDX_W-1:0] ack_src,
    output logic             ack_none
);

    localparam logic [AW-1:0] A_CUR     = AW'(N_SRC + OFS_CUR);
    localparam logic [AW-1:0] A_SAV     = AW'(N_SRC + OFS_SAV);
    localparam logic [AW-1:0] A_CFG     = AW'(N_SRC + OFS_CFG);
    localparam logic [AW-1:0] A_RESTORE = AW'(N_SRC + OFS_RESTORE);

    logic                       wr_lvl_sel;
    logic [N_SRC-1:0][LV_W-1:0] lvl;
    logic [MW-1:0]              cur_mask;
    logic [MW-1:0]              sav_mask;
    logic                       mask_en;
    cand_t                      win;
    logic                       ack_fire;

    assign wr_lvl_sel = wr_en && (wr_addr < AW'(N_SRC));
    assign ack_fire   = ack && win.valid;

    intc_level_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W), .LV_W(LV_W)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_lvl_sel),
        .wr_idx (wr_addr[IDX_W-1:0]),
        .wr_lvl (wr_data[LV_W-1:0]),
        .lvl_o  (lvl)
    );

    intc_mask_ctrl #(.MW(MW), .LV_W(LV_W)) i_mask (
        .clk        (clk),
        .rst        (rst),
        .sw_cur_we  (wr_en && (wr_addr == A_CUR)),
        .sw_sav_we  (wr_en && (wr_addr == A_SAV)),
        .sw_cfg_we  (wr_en && (wr_addr == A_CFG)),
        .sw_restore (wr_en && (wr_addr == A_RESTORE)),
        .sw_data    (wr_data[MW-1:0]),
        .ack_fire   (ack_fire),
        .ack_lvl    (win.lvl),
        .cur_mask   (cur_mask),
        .sav_mask   (sav_mask),
        .mask_en    (mask_en)
    );

    intc_prio_tree #(.N_SRC(N_SRC), .IDX_W(IDX_W), .LV_W(LV_W), .MW(MW)) i_tree (
        .clk      (clk),
        .rst      (rst),
        .irq      (irq),
        .lvl_i    (lvl),
        .cur_mask (cur_mask),
        .win_o    (win)
    );

    assign int_valid = win.valid;
    assign int_level = win.valid ? win.lvl : '0;
    assign int_src   = win.valid ? win.src : '0;
    assign ack_src   = ack_fire ? win.src : '0;
    assign ack_none  = ack && !win.valid;

    always_comb begin
        rd_data = '0;
        if (rd_addr < AW'(N_SRC))
            rd_data = DW'(lvl[rd_addr[IDX_W-1:0]]);
        else if (rd_addr == A_CUR)
            rd_data = DW'(cur_mask);
        else if (rd_addr == A_SAV)
            rd_data = DW'(sav_mask);
        else if (rd_addr == A_CFG)
            rd_data = DW'(mask_en);
    end

    AST_IDLE_ACK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_valid && !wr_en) |=> ($stable(cur_mask) && $stable(sav_mask))); // R8
    AST_ACK_NAMES_WINNER: assert property (@(posedge clk) disable iff (rst)
        (ack && int_valid) |-> (ack_src == int_src && !ack_none)); // R7

endmodule

// File: tb/test_intc_level_top.sv
module test_intc_level_top;

    localparam int NV = 11;
    localparam logic [6:0] A_CUR = 7'h40, A_SAV = 7'h41, A_CFG = 7'h42, A_RST = 7'h43;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        int_valid;
    logic [2:0]  int_level;
    logic [5:0]  int_src;
    logic        ack = 1'b0;
    logic [5:0]  ack_src;
    logic        ack_none;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    intc_level_top i_intc_level_top (
        .clk(clk), .rst(rst), .irq(irq), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .int_valid(int_valid), .int_level(int_level), .int_src(int_src),
        .ack(ack), .ack_src(ack_src), .ack_none(ack_none)
    );

    // vectors assume source n programmed to level n mod 8
    localparam logic [63:0] V_IRQ [NV] = '{
        64'h0, 64'h2, 64'h100, 64'h6, 64'h8080, {64{1'b1}}, {64{1'b1}},
        {64{1'b1}}, 64'h4060, 64'h2020, 64'h1000_0000_0000_0008 };
    localparam logic [3:0] V_MASK [NV] = '{0, 0, 0, 0, 0, 0, 6, 7, 5, 5, 3};
    localparam logic       V_VAL  [NV] = '{0, 1, 0, 1, 1, 1, 1, 0, 1, 0, 1};
    localparam logic [2:0] V_LVL  [NV] = '{0, 1, 0, 2, 7, 7, 7, 0, 6, 0, 4};
    localparam logic [5:0] V_SRC  [NV] = '{0, 1, 0, 2, 15, 63, 63, 0, 14, 0, 60};
    localparam string      V_REQ  [NV] = '{"R3", "R4", "R3", "R4", "R5", "R5",
                                           "R6", "R6", "R6", "R6", "R6"};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [6:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, 64'(rd_data), 64'(exp));
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        #1;
    endtask

    task automatic end_ack();
        @(negedge clk);
        ack = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        rd_check("R2", 7'h00, 8'h00);
        rd_check("R2", 7'h3F, 8'h00);
        rd_check("R2", A_CUR, 8'h00);
        rd_check("R2", A_SAV, 8'h0F);
        rd_check("R2", A_CFG, 8'h00);
        irq = '1; #1;
        check("R3", 64'(int_valid), 64'd0);

        // R1 reserved bits read zero
        wr(7'h05, 8'hFF);
        rd_check("R1", 7'h05, 8'h07);

        for (int i = 0; i < 64; i++) wr(7'(i), 8'(i % 8));

        for (int v = 0; v < NV; v++) begin
            wr(A_CUR, 8'(V_MASK[v]));
            irq = V_IRQ[v];
            #1;
            check(V_REQ[v], 64'(int_valid), 64'(V_VAL[v]));
            if (V_VAL[v]) begin
                check(V_REQ[v], 64'(int_level), 64'(V_LVL[v]));
                check(V_REQ[v], 64'(int_src), 64'(V_SRC[v]));
            end
        end

        // R11 register readback and unmapped reads
        rd_check("R11", A_CUR, 8'h03);
        rd_check("R11", 7'h50, 8'h00);
        wr(A_SAV, 8'hF9);
        rd_check("R11", A_SAV, 8'h09);

        // R7 auto-mask on acknowledge
        wr(A_CUR, 8'h00);
        wr(A_SAV, 8'h0F);
        wr(A_CFG, 8'h01);
        rd_check("R11", A_CFG, 8'h01);
        irq = '0; irq[63] = 1'b1; irq[2] = 1'b1;
        do_ack();
        check("R7", 64'(ack_src), 64'd63);
        check("R7", 64'(ack_none), 64'd0);
        end_ack();
        rd_check("R7", A_CUR, 8'h07);
        rd_check("R7", A_SAV, 8'h00);
        check("R7", 64'(int_valid), 64'd0);

        // R10 restore
        wr(A_RST, 8'h00);
        rd_check("R10", A_CUR, 8'h00);
        check("R10", 64'(int_src), 64'd63);

        // R7 nested: mask 1 saved
        wr(A_CUR, 8'h01);
        do_ack();
        end_ack();
        rd_check("R7", A_SAV, 8'h01);
        wr(A_RST, 8'h00);
        rd_check("R10", A_CUR, 8'h01);

        // R8 acknowledge with nothing pending
        irq = '0;
        do_ack();
        check("R8", 64'(ack_none), 64'd1);
        check("R8", 64'(ack_src), 64'd0);
        end_ack();
        rd_check("R8", A_CUR, 8'h01);
        rd_check("R8", A_SAV, 8'h01);

        // R9 mask disabled
        wr(A_CFG, 8'h00);
        irq[2] = 1'b1;
        do_ack();
        check("R9", 64'(ack_src), 64'd2);
        end_ack();
        rd_check("R9", A_CUR, 8'h01);
        rd_check("R9", A_SAV, 8'h01);

        // R12 ack wins over same-cycle mask write
        wr(A_CFG, 8'h01);
        @(negedge clk);
        ack = 1'b1; wr_en = 1'b1; wr_addr = A_CUR; wr_data = 8'h05;
        @(negedge clk);
        ack = 1'b0; wr_en = 1'b0;
        rd_check("R12", A_CUR, 8'h02);
        rd_check("R12", A_SAV, 8'h01);

        // R1 / R3 level write takes effect next cycle
        wr(A_CUR, 8'h00);
        #1;
        check("R1", 64'(int_src), 64'd2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'h02; wr_data = 8'h00;
        #1;
        check("R1", 64'(int_valid), 64'd1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R3", 64'(int_valid), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule